// File: doc/BRIEF.md
# Heart-Rate Window Alarm

This block watches a heartbeat stream and raises an interrupt-style alarm when the heart rate leaves a programmed safe range. Its inputs are a one-cycle pulse for each detected beat and a free-running timebase enable. It counts timebase ticks between consecutive beats and reports each completed interval as the latest period. It then tests that period against a lower and an upper tick limit.

Every completed interval produces a per-beat out-of-range flag. The flag is pushed into a short history register. An alarm condition exists only while every entry in that history is out of range, so a single stray beat cannot raise an alarm on its own. The condition then passes through a hold-time filter before it drives the alarm output.

The interval counter stops at its largest value rather than wrapping. A beat that never arrives therefore still ends up marked as out of range. Analog front-end conditioning and beat detection take place upstream of this block.

Top module: `hrw_alarm_top`

## Requirements
- R1: After reset, `period_o` is 0, `out_of_range_o` is 0 and `alarm_o` is 0.
- R2: The first `peak_i` after reset only starts timing. `period_o` and `out_of_range_o` keep their values, and the history is not shifted.
- R3: On every later `peak_i`, `period_o` takes the number of cycles with `tick_i` high since the previous peak. A tick in the same cycle as a peak is not counted. The new value is visible from the cycle after the peak and is held until the next peak.
- R4: `out_of_range_o` is 1 when the captured period is greater than `lim_hi_i` or less than `lim_lo_i`. A period equal to either limit is in range.
- R5: The interval count saturates at 2^CNT_W-1. A saturated period is flagged out of range whatever the limits are.
- R6: The alarm condition holds only when the last HIST_DEPTH flags (default 2) are all 1. A single out-of-range beat between in-range beats never raises `alarm_o`.
- R7: One in-range period removes the alarm condition, and `alarm_o` then falls after the hold time.
- R8: `alarm_o` changes only after the condition has differed from it for DEB_CYCLES (default 4) consecutive clock cycles. Counting the peak edge that changes the condition as edge 0, `alarm_o` changes at edge DEB_CYCLES.
- R9: With one tick per millisecond and limits of 600 and 1000 ticks, a steady 72 beats/min (833 ticks) keeps `alarm_o` low. Steady 50 beats/min (1200 ticks) and steady 110 beats/min (545 ticks) each raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| peak_i | input | 1 | One-cycle pulse per detected beat |
| tick_i | input | 1 | Timebase enable; each high cycle adds one to the interval |
| lim_lo_i | input | CNT_W | Lowest in-range period, in ticks |
| lim_hi_i | input | CNT_W | Highest in-range period, in ticks |
| period_o | output | CNT_W | Most recent completed interval, in ticks |
| out_of_range_o | output | 1 | Flag for the most recent interval |
| alarm_o | output | 1 | Filtered alarm |

## Verification
The bench builds the block with CNT_W = 12 and keeps HIST_DEPTH = 2 and DEB_CYCLES = 4. The narrow counter brings saturation within reach in about 8,000 cycles, so the missing-beat case runs next to the realistic 50, 72 and 110 beats/min intervals. The bench samples the alarm at every edge after each beat, so the exact hold-time edge is checked, not only the final level. Beats placed on and one tick beyond each limit exercise the inclusive window.

// File: rtl/hrw_pkg.sv
package hrw_pkg;
   // Library defaults shared by the top and its checker
   localparam int unsigned HRW_CNT_W_DEF      = 16;
   localparam int unsigned HRW_HIST_DEPTH_DEF = 2;
   localparam int unsigned HRW_DEB_CYCLES_DEF = 4;

   // Debounce counter width for a given hold time
   function automatic int unsigned hrw_deb_w(input int unsigned hold);
      return (hold <= 2) ? 1 : $clog2(hold);
   endfunction
endpackage

// File: rtl/hrw_interval_timer.sv
module hrw_interval_timer #(
   parameter int unsigned CNT_W = hrw_pkg::HRW_CNT_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             peak_i,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             armed_o,
   output logic             capture_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;

   initial begin
      assert (CNT_W >= 2) else $error("hrw_interval_timer: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         if (peak_i) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
         end else if (tick_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cnt_o     = cnt_q;
   assign armed_o   = armed_q;
   assign capture_o = peak_i & armed_q;
endmodule

// File: rtl/hrw_window_cmp.sv
module hrw_window_cmp #(
   parameter int unsigned CNT_W = hrw_pkg::HRW_CNT_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] lim_lo_i,
   input  logic [CNT_W-1:0] lim_hi_i,
   output logic [CNT_W-1:0] period_o,
   output logic             oor_o,
   output logic             oor_now_o
);
   logic [CNT_W-1:0] period_q;
   logic             oor_q;
   logic             too_long, too_short, saturated;

   always_comb begin
      too_long  = (cnt_i > lim_hi_i);
      too_short = (cnt_i < lim_lo_i);
      saturated = &cnt_i;
      oor_now_o = too_long | too_short | saturated;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '0;
         oor_q    <= 1'b0;
      end else if (capture_i) begin
         period_q <= cnt_i;
         oor_q    <= oor_now_o;
      end
   end

   assign period_o = period_q;
   assign oor_o    = oor_q;
endmodule

// File: rtl/hrw_history.sv
module hrw_history #(
   parameter int unsigned DEPTH = hrw_pkg::HRW_HIST_DEPTH_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_i,
   input  logic bit_i,
   output logic cond_o
);
   initial begin
      assert (DEPTH >= 1) else $error("hrw_history: DEPTH must be at least 1");
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic last_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       last_q <= 1'b0;
            else if (shift_i) last_q <= bit_i;
         end
         assign cond_o = last_q;
      end else begin : g_shift
         logic [DEPTH-1:0] hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       hist_q <= '0;
            else if (shift_i) hist_q <= {hist_q[DEPTH-2:0], bit_i};
         end
         assign cond_o = &hist_q;
      end
   endgenerate
endmodule

// File: rtl/hrw_debounce.sv
module hrw_debounce #(
   parameter int unsigned HOLD = hrw_pkg::HRW_DEB_CYCLES_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic out_o
);
   localparam int unsigned DW = hrw_pkg::hrw_deb_w(HOLD);
   localparam logic [DW-1:0] LAST = DW'(HOLD - 1);

   initial begin
      assert (HOLD >= 1) else $error("hrw_debounce: HOLD must be at least 1");
   end

   generate
      if (HOLD == 1) begin : g_direct
         logic out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= 1'b0;
            else        out_q <= raw_i;
         end
         assign out_o = out_q;
      end else begin : g_count
         logic          out_q;
         logic [DW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_q <= 1'b0;
               run_q <= '0;
            end else if (raw_i == out_q) begin
               run_q <= '0;
            end else if (run_q == LAST) begin
               out_q <= raw_i;
               run_q <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
         assign out_o = out_q;
      end
   endgenerate
endmodule

// File: rtl/hrw_alarm_top.sv
module hrw_alarm_top #(
   parameter int unsigned CNT_W      = hrw_pkg::HRW_CNT_W_DEF,
   parameter int unsigned HIST_DEPTH = hrw_pkg::HRW_HIST_DEPTH_DEF,
   parameter int unsigned DEB_CYCLES = hrw_pkg::HRW_DEB_CYCLES_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             peak_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] lim_lo_i,
   input  logic [CNT_W-1:0] lim_hi_i,
   output logic [CNT_W-1:0] period_o,
   output logic             out_of_range_o,
   output logic             alarm_o
);
   logic [CNT_W-1:0] cnt_w;
   logic             armed_w;
   logic             cap_w;
   logic             oor_now_w;
   logic             cond_w;

   hrw_interval_timer #(.CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .peak_i    (peak_i),
      .tick_i    (tick_i),
      .cnt_o     (cnt_w),
      .armed_o   (armed_w),
      .capture_o (cap_w)
   );

   hrw_window_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (cap_w),
      .cnt_i     (cnt_w),
      .lim_lo_i  (lim_lo_i),
      .lim_hi_i  (lim_hi_i),
      .period_o  (period_o),
      .oor_o     (out_of_range_o),
      .oor_now_o (oor_now_w)
   );

   hrw_history #(.DEPTH(HIST_DEPTH)) u_hist (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (cap_w),
      .bit_i   (oor_now_w),
      .cond_o  (cond_w)
   );

   hrw_debounce #(.HOLD(DEB_CYCLES)) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (cond_w),
      .out_o (alarm_o)
   );
endmodule

// File: rtl/hrw_alarm_chk.sv
module hrw_alarm_chk #(
   parameter int unsigned CNT_W      = hrw_pkg::HRW_CNT_W_DEF,
   parameter int unsigned DEB_CYCLES = hrw_pkg::HRW_DEB_CYCLES_DEF
) (
   input logic             clk,
   input logic             rst_n,
   input logic             peak_i,
   input logic             armed,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] lim_lo,
   input logic [CNT_W-1:0] lim_hi,
   input logic [CNT_W-1:0] period,
   input logic             oor,
   input logic             cond,
   input logic             alarm
);
   localparam int unsigned RW = $clog2(DEB_CYCLES + 1) + 1;
   localparam logic [RW-1:0] RUN_CAP = RW'(DEB_CYCLES);
   localparam logic [RW-1:0] RUN_MIN = RW'(DEB_CYCLES - 1);

   // Consecutive cycles in which the condition differs from the output
   logic [RW-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             run_q <= '0;
      else if (cond == alarm) run_q <= '0;
      else if (run_q != RUN_CAP) run_q <= run_q + 1'b1;
   end

   // R2: the arming peak leaves the outputs alone
   p_arm_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (peak_i && !armed) |=> ($stable(period) && $stable(oor)));

   // R3: the period holds between peaks
   p_period_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !peak_i |=> $stable(period));

   // R4: the flag agrees with the captured period and the limits
   p_flag_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (peak_i && armed) |=>
         (oor == ((period > $past(lim_hi)) || (period < $past(lim_lo)) || (&period))));

   // R5: a saturated interval is always flagged
   p_sat_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (peak_i && armed && (&cnt)) |=> oor);

   // R7: an in-range latest period means no alarm condition
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !oor |-> !cond);

   // R8: the alarm changes only after the full hold time
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm != $past(alarm)) |-> ($past(run_q) >= RUN_MIN));
endmodule

bind hrw_alarm_top hrw_alarm_chk #(.CNT_W(CNT_W), .DEB_CYCLES(DEB_CYCLES)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .peak_i (peak_i),
   .armed  (armed_w),
   .cnt    (cnt_w),
   .lim_lo (lim_lo_i),
   .lim_hi (lim_hi_i),
   .period (period_o),
   .oor    (out_of_range_o),
   .cond   (cond_w),
   .alarm  (alarm_o)
);

// File: tb/hrw_alarm_top_tb_top.sv
module hrw_alarm_top_tb_top;
   localparam int unsigned CW = 12;
   localparam int unsigned SAT = (1 << CW) - 1;

   typedef struct {
      int unsigned per;
      bit          oor;
      bit          al_before;
      bit          al_after;
      string       tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          peak_i = 1'b0;
   logic          tick_i = 1'b0;
   logic [CW-1:0] lim_lo_i = '0;
   logic [CW-1:0] lim_hi_i = '0;
   logic [CW-1:0] period_o;
   logic          out_of_range_o;
   logic          alarm_o;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   item_t       sb_q[$];
   bit          armed_tb = 1'b0;
   bit          h0 = 1'b0, h1 = 1'b0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   hrw_alarm_top #(.CNT_W(CW)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .peak_i         (peak_i),
      .tick_i         (tick_i),
      .lim_lo_i       (lim_lo_i),
      .lim_hi_i       (lim_hi_i),
      .period_o       (period_o),
      .out_of_range_o (out_of_range_o),
      .alarm_o        (alarm_o)
   );

   task automatic chk(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // Driver: n ticks (one every other cycle), then one peak cycle
   task automatic beat(input int unsigned n, input string tag);
      item_t it;
      if (armed_tb) begin
         it.per       = (n > SAT) ? SAT : n;
         it.oor       = (it.per > lim_hi_i) || (it.per < lim_lo_i) || (it.per == SAT);
         it.al_before = h0 & h1;
         h1 = h0;
         h0 = it.oor;
         it.al_after  = h0 & h1;
         it.tag       = tag;
         sb_q.push_back(it);
      end
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick_i = 1'b1;
         @(negedge clk) tick_i = 1'b0;
      end
      @(negedge clk) peak_i = 1'b1;
      @(negedge clk) peak_i = 1'b0;
      armed_tb = 1'b1;
   endtask

   // Monitor: pops one expected item per scored beat
   initial begin
      item_t it;
      forever begin
         @(posedge clk);
         if (peak_i && armed_tb) begin
            @(negedge clk);
            if (sb_q.size() == 0) begin
               chk(1'b0, "R3 unexpected beat", 1, 0);
            end else begin
               it = sb_q.pop_front();
               chk(period_o == it.per, {it.tag, " R3 period"}, period_o, it.per);
               chk(out_of_range_o == it.oor, {it.tag, " R4 flag"}, out_of_range_o, it.oor);
               chk(alarm_o == it.al_before, {it.tag, " R8 alarm at edge 0"}, alarm_o, it.al_before);
               repeat (3) @(negedge clk);
               chk(alarm_o == it.al_before, {it.tag, " R8 alarm at edge 3"}, alarm_o, it.al_before);
               @(negedge clk);
               chk(alarm_o == it.al_after, {it.tag, " R8 alarm at edge 4"}, alarm_o, it.al_after);
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(period_o == 0, "R1 period", period_o, 0);
      chk(out_of_range_o == 0, "R1 flag", out_of_range_o, 0);
      chk(alarm_o == 0, "R1 alarm", alarm_o, 0);
      @(negedge clk) rst_n = 1'b1;
      lim_lo_i = 12'd600;
      lim_hi_i = 12'd1000;

      // R2 arming peak after a short interval below the low limit
      beat(50, "R2 arm");
      @(negedge clk);
      chk(period_o == 0, "R2 period unchanged", period_o, 0);
      chk(out_of_range_o == 0, "R2 flag unchanged", out_of_range_o, 0);

      // R9 steady 72 bpm
      beat(833, "R9 72bpm");
      beat(833, "R9 72bpm");
      // R6 single slow beat: no alarm
      beat(1200, "R6 glitch");
      beat(833, "R6 recover");
      // R9 steady 50 bpm raises the alarm
      beat(1200, "R9 50bpm");
      beat(1200, "R9 50bpm");
      // R7 one in-range beat clears
      beat(833, "R7 clear");
      // R9 steady 110 bpm raises the alarm
      beat(545, "R9 110bpm");
      beat(545, "R9 110bpm");
      // R4 inclusive limits
      beat(600, "R4 at low limit");
      beat(1000, "R4 at high limit");
      beat(1001, "R4 above high");
      beat(599, "R4 below low");
      beat(1000, "R7 clear at limit");
      // R5 saturation flagged even with the top limit wide open
      lim_hi_i = 12'(SAT);
      beat(4200, "R5 saturated");
      beat(4200, "R5 saturated twice");
      lim_hi_i = 12'd1000;
      beat(833, "R7 clear after sat");

      repeat (12) @(negedge clk);
      chk(sb_q.size() == 0, "R3 all beats scored", sb_q.size(), 0);
      done = 1'b1;
      summary();
   end
endmodule